// File: doc/BRIEF.md
# Precise Exception Status Tracker

This block runs beside a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It keeps a small exception status vector for each instruction in flight. Every stage may post fault strobes against the instruction it currently holds. Posted faults are only recorded in that instruction's vector. Nothing is acted on until the instruction reaches write-back.

In write-back, a clean vector lets the instruction commit. A non-zero vector raises a trap instead. On a trap the block blocks the instruction's own update and flushes every younger instruction. It reports a 3-bit cause code, the faulting PC, and a second restart PC. The second PC is the branch target when the faulting instruction sits in a branch delay slot, and the next sequential PC otherwise. One cycle later it requests a fetch redirect to a fixed handler address.

The pipeline advances one stage per cycle. The pipeline's write-back logic gates its register write with `commit_o`, and the memory stage gates its store with `mem_wr_ok_o`.

Top module: `precise_trap_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after release, `trap_o`, `commit_o`, `redirect_o` and `mem_wr_ok_o` are low.
- R2: An instruction presented at fetch with no faults posted against it raises `commit_o`, with `retire_pc_o` equal to its PC, exactly four cycles later, provided no older trap flushes it.
- R3: Fault bits are stored at fixed vector positions. The fetch and memory strobe inputs each use bit0 for page fault, bit1 for misaligned access and bit2 for protection violation. The reported cause code is the index of the lowest set vector bit, so the earliest stage's cause wins. The codes are: 0 fetch page fault, 1 fetch misaligned, 2 fetch protection, 3 illegal opcode, 4 arithmetic, 5 data page fault, 6 data misaligned, 7 data protection.
- R4: `trap_o` rises only in the cycle in which a faulted instruction occupies write-back. Faults posted in earlier stages produce no trap before then.
- R5: When several stages post faults in the same cycle, the oldest instruction's fault is the one reported.
- R6: On a trap, the instructions in decode, execute and memory, the instruction at fetch in the trap cycle, and the instruction at fetch in the following cycle are all discarded. None of them later commits or traps.
- R7: `mem_wr_ok_o` is high only when the memory stage holds a valid instruction, no fault has been posted against it (including a memory strobe in the same cycle), and no trap is being taken that cycle.
- R8: In the cycle after `trap_o`, `redirect_o` is high and `redirect_pc_o` equals HANDLER_PC (default 0x80).
- R9: With `trap_o`, `retire_pc_o` is the faulting PC and `trap_slot_o` is its delay-slot flag. `restart_pc_o` is the branch target given at fetch if the flag is set, and PC+4 otherwise.
- R10: `commit_o` is low whenever `trap_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| if_valid_i | input | 1 | An instruction is at fetch this cycle |
| if_pc_i | input | PC_W | PC of the fetched instruction |
| if_slot_i | input | 1 | Fetched instruction is in a branch delay slot |
| if_tgt_i | input | PC_W | Branch target associated with a delay-slot instruction |
| if_fault_i | input | 3 | Fetch fault strobes (page, misaligned, protection) |
| id_illegal_i | input | 1 | Decode-stage illegal opcode strobe |
| ex_arith_i | input | 1 | Execute-stage arithmetic fault strobe |
| mem_fault_i | input | 3 | Memory fault strobes (page, misaligned, protection) |
| mem_wr_ok_o | output | 1 | Memory-stage store may proceed |
| commit_o | output | 1 | Write-back instruction may update state |
| retire_pc_o | output | PC_W | PC of the write-back instruction |
| trap_o | output | 1 | Trap taken this cycle |
| trap_cause_o | output | 3 | Cause code of the trap |
| trap_slot_o | output | 1 | Faulting instruction was in a delay slot |
| restart_pc_o | output | PC_W | Second restart PC |
| redirect_o | output | 1 | Fetch must redirect to the handler |
| redirect_pc_o | output | PC_W | Handler address |

## Verification
The assertions assume the pipeline advances every cycle. They also assume that fault strobes mean something only when the matching stage holds an instruction, so a strobe against an empty stage is simply dropped. The stimulus keeps to a one-stage-per-cycle flow but drives strobes freely, including against empty or squashed stages and several stages at once. Both the directed sequences and the random phase keep the fault rate low enough that most instructions commit between traps.

// File: rtl/ptu_pkg.sv
`timescale 1ns/1ps
package ptu_pkg;
  localparam int unsigned VEC_W = 8;
  localparam int unsigned CODE_W = 3;
  typedef enum logic [CODE_W-1:0] {
    CAUSE_FETCH_PF   = 3'd0,
    CAUSE_FETCH_MIS  = 3'd1,
    CAUSE_FETCH_PROT = 3'd2,
    CAUSE_ILLEGAL    = 3'd3,
    CAUSE_ARITH      = 3'd4,
    CAUSE_DATA_PF    = 3'd5,
    CAUSE_DATA_MIS   = 3'd6,
    CAUSE_DATA_PROT  = 3'd7
  } cause_e;
endpackage

// File: rtl/ptu_stage.sv
`timescale 1ns/1ps
module ptu_stage
  import ptu_pkg::*;
#(
  parameter int unsigned PC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             valid_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             slot_i,
  input  logic [PC_W-1:0]  tgt_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [VEC_W-1:0] post_i,
  output logic             valid_o,
  output logic [PC_W-1:0]  pc_o,
  output logic             slot_o,
  output logic [PC_W-1:0]  tgt_o,
  output logic [VEC_W-1:0] vec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pc_o    <= '0;
      slot_o  <= 1'b0;
      tgt_o   <= '0;
      vec_o   <= '0;
    end else if (flush_i) begin
      valid_o <= 1'b0;
      vec_o   <= '0;
    end else begin
      valid_o <= valid_i;
      pc_o    <= pc_i;
      slot_o  <= slot_i;
      tgt_o   <= tgt_i;
      // strobes only land on an occupied stage
      vec_o   <= valid_i ? (vec_i | post_i) : '0;
    end
  end
endmodule

// File: rtl/ptu_cause_enc.sv
`timescale 1ns/1ps
module ptu_cause_enc
  import ptu_pkg::*;
(
  input  logic [VEC_W-1:0] vec_i,
  output cause_e           cause_o
);
  // lowest set bit = earliest stage
  always_comb begin
    cause_o = CAUSE_FETCH_PF;
    for (int i = VEC_W - 1; i >= 0; i--) begin
      if (vec_i[i]) cause_o = cause_e'(i[CODE_W-1:0]);
    end
  end
endmodule

// File: rtl/precise_trap_unit.sv
`timescale 1ns/1ps
module precise_trap_unit
  import ptu_pkg::*;
#(
  parameter int unsigned       PC_W       = 32,
  parameter logic [PC_W-1:0]   HANDLER_PC = 32'h0000_0080,
  parameter int unsigned       INSN_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              if_valid_i,
  input  logic [PC_W-1:0]   if_pc_i,
  input  logic              if_slot_i,
  input  logic [PC_W-1:0]   if_tgt_i,
  input  logic [2:0]        if_fault_i,
  input  logic              id_illegal_i,
  input  logic              ex_arith_i,
  input  logic [2:0]        mem_fault_i,
  output logic              mem_wr_ok_o,
  output logic              commit_o,
  output logic [PC_W-1:0]   retire_pc_o,
  output logic              trap_o,
  output logic [CODE_W-1:0] trap_cause_o,
  output logic              trap_slot_o,
  output logic [PC_W-1:0]   restart_pc_o,
  output logic              redirect_o,
  output logic [PC_W-1:0]   redirect_pc_o
);
  localparam int unsigned NSTG = 4;         // decode, execute, memory, write-back
  localparam int unsigned MEM  = NSTG - 1;
  localparam int unsigned WB   = NSTG;

  logic             v_s    [NSTG+1];
  logic [PC_W-1:0]  pc_s   [NSTG+1];
  logic             slot_s [NSTG+1];
  logic [PC_W-1:0]  tgt_s  [NSTG+1];
  logic [VEC_W-1:0] vec_s  [NSTG+1];
  logic [VEC_W-1:0] post_s [NSTG];

  logic   redirect_q;
  logic   trap;
  cause_e cause;

  // index 0 is the fetch slot, fed from the ports
  assign v_s[0]    = if_valid_i & ~redirect_q;
  assign pc_s[0]   = if_pc_i;
  assign slot_s[0] = if_slot_i;
  assign tgt_s[0]  = if_tgt_i;
  assign vec_s[0]  = '0;

  assign post_s[0] = {5'b0, if_fault_i};
  assign post_s[1] = {4'b0, id_illegal_i, 3'b0};
  assign post_s[2] = {3'b0, ex_arith_i, 4'b0};
  assign post_s[3] = {mem_fault_i, 5'b0};

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    ptu_stage #(.PC_W(PC_W)) i_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (trap),
      .valid_i (v_s[g]),
      .pc_i    (pc_s[g]),
      .slot_i  (slot_s[g]),
      .tgt_i   (tgt_s[g]),
      .vec_i   (vec_s[g]),
      .post_i  (post_s[g]),
      .valid_o (v_s[g+1]),
      .pc_o    (pc_s[g+1]),
      .slot_o  (slot_s[g+1]),
      .tgt_o   (tgt_s[g+1]),
      .vec_o   (vec_s[g+1])
    );
  end

  ptu_cause_enc i_enc (
    .vec_i   (vec_s[WB]),
    .cause_o (cause)
  );

  assign trap     = v_s[WB] & (|vec_s[WB]);
  assign commit_o = v_s[WB] & ~(|vec_s[WB]);
  assign trap_o   = trap;

  assign mem_wr_ok_o = v_s[MEM] & ~trap & ~(|(vec_s[MEM] | post_s[MEM]));

  assign retire_pc_o  = pc_s[WB];
  assign trap_cause_o = cause;
  assign trap_slot_o  = slot_s[WB];
  assign restart_pc_o = slot_s[WB] ? tgt_s[WB] : pc_s[WB] + PC_W'(INSN_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) redirect_q <= 1'b0;
    else         redirect_q <= trap;
  end

  assign redirect_o    = redirect_q;
  assign redirect_pc_o = HANDLER_PC;
endmodule

// File: rtl/ptu_checker.sv
`timescale 1ns/1ps
module ptu_checker #(
  parameter int unsigned     PC_W       = 32,
  parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            trap_o,
  input logic            commit_o,
  input logic            mem_wr_ok_o,
  input logic            redirect_o,
  input logic [PC_W-1:0] redirect_pc_o
);
  assert_no_commit_on_trap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !commit_o);

  assert_no_store_on_trap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !mem_wr_ok_o);

  assert_redirect_after_trap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> redirect_o && redirect_pc_o == HANDLER_PC);

  assert_wb_empty_after_trap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> !trap_o && !commit_o ##1 !trap_o && !commit_o);

  assert_redirect_only_after_trap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(redirect_o) |-> $past(trap_o));
endmodule

bind precise_trap_unit ptu_checker #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) i_ptu_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .trap_o        (trap_o),
  .commit_o      (commit_o),
  .mem_wr_ok_o   (mem_wr_ok_o),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o)
);

// File: tb/test_precise_trap_unit.sv
`timescale 1ns/1ps
module test_precise_trap_unit;
  localparam logic [31:0] HANDLER = 32'h0000_0080;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        if_valid_i = 1'b0;
  logic [31:0] if_pc_i = '0;
  logic        if_slot_i = 1'b0;
  logic [31:0] if_tgt_i = '0;
  logic [2:0]  if_fault_i = '0;
  logic        id_illegal_i = 1'b0;
  logic        ex_arith_i = 1'b0;
  logic [2:0]  mem_fault_i = '0;
  logic        mem_wr_ok_o, commit_o, trap_o, trap_slot_o, redirect_o;
  logic [31:0] retire_pc_o, restart_pc_o, redirect_pc_o;
  logic [2:0]  trap_cause_o;

  always #2 clk_i = ~clk_i;

  precise_trap_unit #(.PC_W(32), .HANDLER_PC(HANDLER)) i_precise_trap_unit (
    .clk_i, .rst_ni, .if_valid_i, .if_pc_i, .if_slot_i, .if_tgt_i, .if_fault_i,
    .id_illegal_i, .ex_arith_i, .mem_fault_i, .mem_wr_ok_o, .commit_o, .retire_pc_o,
    .trap_o, .trap_cause_o, .trap_slot_o, .restart_pc_o, .redirect_o, .redirect_pc_o
  );

  typedef struct {
    logic [31:0] pc;
    bit          slot;
    logic [31:0] tgt;
    logic [7:0]  vec;
    int          stg;   // 1 decode .. 4 write-back
  } rec_t;

  rec_t        q[$];
  bit          exp_redirect = 0;
  logic [31:0] fetch_pc = 32'h100;
  int          nchk = 0;
  int          nerr = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int low_bit(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic step(bit v, bit sl, logic [31:0] tg, logic [2:0] ff, bit il, bit ar,
                      logic [2:0] mf);
    int wb = -1;
    int mi = -1;
    bit e_trap, e_commit, e_mem;
    @(negedge clk_i);
    if_valid_i = v; if_pc_i = fetch_pc; if_slot_i = sl; if_tgt_i = tg;
    if_fault_i = ff; id_illegal_i = il; ex_arith_i = ar; mem_fault_i = mf;
    #1;
    foreach (q[i]) begin
      if (q[i].stg == 4) wb = i;
      if (q[i].stg == 3) mi = i;
    end
    e_trap   = (wb >= 0) && (q[wb].vec != 0);
    e_commit = (wb >= 0) && (q[wb].vec == 0);
    e_mem    = (mi >= 0) && !e_trap && ((q[mi].vec | {mf, 5'b0}) == 0);
    chk("R4", "trap_o", 32'(trap_o), 32'(e_trap));
    chk("R2", "commit_o", 32'(commit_o), 32'(e_commit));
    chk("R7", "mem_wr_ok_o", 32'(mem_wr_ok_o), 32'(e_mem));
    chk("R8", "redirect_o", 32'(redirect_o), 32'(exp_redirect));
    if (exp_redirect) chk("R8", "redirect_pc_o", redirect_pc_o, HANDLER);
    if (e_commit) chk("R2", "retire_pc_o", retire_pc_o, q[wb].pc);
    if (e_trap) begin
      chk("R3", "trap_cause_o", 32'(trap_cause_o), 32'(low_bit(q[wb].vec)));
      chk("R9", "retire_pc_o", retire_pc_o, q[wb].pc);
      chk("R9", "trap_slot_o", 32'(trap_slot_o), 32'(q[wb].slot));
      chk("R9", "restart_pc_o", restart_pc_o, q[wb].slot ? q[wb].tgt : q[wb].pc + 4);
    end
    // state after the coming edge
    if (e_trap) begin
      q.delete();
    end else begin
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].stg == 1 && il) q[i].vec[3] = 1'b1;
        if (q[i].stg == 2 && ar) q[i].vec[4] = 1'b1;
        if (q[i].stg == 3) q[i].vec[7:5] = q[i].vec[7:5] | mf;
        q[i].stg++;
        if (q[i].stg > 4) q.delete(i);
      end
      if (v && !exp_redirect) begin
        rec_t r;
        r.pc = fetch_pc; r.slot = sl; r.tgt = tg; r.vec = {5'b0, ff}; r.stg = 1;
        q.push_back(r);
      end
    end
    exp_redirect = e_trap;
    fetch_pc += 4;
  endtask

  task automatic clean();
    step(1, 0, 0, 3'b0, 0, 0, 3'b0);
  endtask

  initial begin
    #150000;
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [31:0] a_pc;
    logic [31:0] tgt;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1", "trap_o in reset", 32'(trap_o), 0);
    chk("R1", "commit_o in reset", 32'(commit_o), 0);
    chk("R1", "redirect_o in reset", 32'(redirect_o), 0);
    chk("R1", "mem_wr_ok_o in reset", 32'(mem_wr_ok_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(0, 0, 0, 3'b0, 0, 0, 3'b0);
    chk("R1", "trap_o after reset", 32'(trap_o), 0);
    chk("R1", "commit_o after reset", 32'(commit_o), 0);

    // R5: faults in memory, execute, decode and fetch in one cycle
    a_pc = fetch_pc;
    clean(); clean(); clean();
    step(1, 0, 0, 3'b001, 1, 1, 3'b001);
    chk("R4", "no early trap", 32'(trap_o), 0);
    clean();
    chk("R5", "oldest traps", 32'(trap_o), 1);
    chk("R5", "oldest cause", 32'(trap_cause_o), 5);
    chk("R5", "oldest pc", retire_pc_o, a_pc);
    chk("R10", "no commit with trap", 32'(commit_o), 0);
    for (int k = 0; k < 4; k++) begin
      clean();
      chk("R6", "flushed no trap", 32'(trap_o), 0);
      chk("R6", "flushed no commit", 32'(commit_o), 0);
    end
    repeat (4) clean();

    // R3: earliest cause within one instruction
    step(1, 0, 0, 3'b110, 0, 0, 3'b0);
    step(1, 0, 0, 3'b0, 1, 0, 3'b0);
    clean(); clean(); clean();
    chk("R3", "fetch misaligned beats later causes", 32'(trap_cause_o), 1);
    repeat (5) clean();

    // R9: delay-slot fault keeps the branch target
    tgt = 32'h0000_4440;
    a_pc = fetch_pc;
    step(1, 1, tgt, 3'b0, 0, 0, 3'b0);
    clean();
    step(1, 0, 0, 3'b0, 0, 1, 3'b0);
    clean(); clean();
    chk("R9", "slot flag", 32'(trap_slot_o), 1);
    chk("R9", "slot restart", restart_pc_o, tgt);
    chk("R9", "slot epc", retire_pc_o, a_pc);
    repeat (5) clean();

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      bit          v  = ($urandom % 8) != 0;
      bit          sl = ($urandom % 6) == 0;
      logic [2:0]  ff = '0;
      logic [2:0]  mf = '0;
      for (int b = 0; b < 3; b++) begin
        ff[b] = ($urandom % 40) == 0;
        mf[b] = ($urandom % 40) == 0;
      end
      step(v, sl, $urandom & 32'hffff_fffc, ff, ($urandom % 30) == 0,
           ($urandom % 30) == 0, mf);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule